// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block gathers three groups of 32-bit interrupt sources (a core group, a DMA group and a GPIO group) under one top-level status word and drives one interrupt line. Each group has a raw status word, a mask word, and write-one-to-set and write-one-to-clear addresses. Its source event lines OR into the status every clock. The top-level word holds summary bits that always reflect the masked group contents. The core group contributes two summaries: one for its lower half-word and one for its upper half-word. The top-level word also holds sticky bits set by hardware and by software. Hardware sets them on timeout-counter expiry and on any change of the bus-session status input.

The interrupt line is registered. Its sense is chosen by a control bit. It stays forced low from each rising edge of the power-good input until a settle delay of `SETTLE_CYCLES` clocks has run out with power still present. Software drives the block over a single-cycle synchronous bus: write strobe, word address, 32-bit write data and combinational read data. Reads have no side effects.

Top module: `irq_aggregator`

## Requirements
- R1: Word addresses: control 0; core group 1..4; DMA group 5..8; GPIO group 9..12; top group 13..16; timeout counter 17. Within a group the four addresses are base+0 status, base+1 set, base+2 clear and base+3 mask. A write to set ORs the data into the status. A write to clear removes the bits that are 1 in the data. A write to mask replaces the mask. Reads of status, set or clear return the raw status, including bits that are masked.
- R2: Top status bit 0 is 1 exactly when a core bit in positions 15..0 is pending and unmasked. Bit 1 is the same for core positions 31..16. Software writes to these summary positions have no effect.
- R3: Top status bit 2 summarises the DMA group and bit 3 summarises the GPIO group, each as the OR of its pending unmasked bits.
- R4: Control bit 0 selects the sense of the line. With it at 1, the line is high when a top status bit with a 0 mask bit exists. With it at 0, the line is high when no such bit exists. In both cases the line is high only while the power gate is open.
- R5: The interrupt line updates on the clock edge after the write or event that changes its inputs.
- R6: After reset: top mask reads 0xFFFFFFFF; top status, group status, group masks, control and the timeout counter read 0; the interrupt line is 0.
- R7: A rising edge on `pwr_good` closes the gate (line 0). The gate opens SETTLE_CYCLES clocks later, but only if `pwr_good` is still 1 at that point. If power has dropped by then, the gate stays closed.
- R8: Writing a nonzero value N to address 17 loads the counter, which then decrements once per clock. Writing 0 stops it. On the clock that takes it from 1 to 0, top status bit 4 is set. The address reads back the current count.
- R9: Any change of `vbus_state` from its value on the previous clock sets top status bit 5.
- R10: Event inputs OR into their group status each clock. The top group set, clear and mask addresses act as in R1 on the non-summary bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| core_evt | input | 32 | Core group event pulses |
| dma_evt | input | 32 | DMA group event pulses |
| gpio_evt | input | 32 | GPIO group event pulses |
| pwr_good | input | 1 | Power-present level |
| vbus_state | input | VBUS_W | Bus-session status level |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that a write strobe lasts one cycle, with address and data valid in that cycle. Under those assumptions, a mask write, a counter expiry or a session-status change shows its effect on the next edge. The bench changes every input at the falling edge and gives each bus write exactly one clock. It holds the event lines and `vbus_state` at 0 except in the cycles where a test pulses them on purpose. That way, no unplanned set or sense-change event disturbs the expected status words.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int ADDR_W        = 5,
  parameter int SETTLE_CYCLES = 16,
  parameter int TMO_W         = 32,
  parameter int VBUS_W        = 2,
  parameter int B_TX          = 0,
  parameter int B_RX          = 1,
  parameter int B_DMA         = 2,
  parameter int B_GPIO        = 3,
  parameter int B_TMO         = 4,
  parameter int B_VBUS        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       core_evt,
  input  logic [31:0]       dma_evt,
  input  logic [31:0]       gpio_evt,
  input  logic              pwr_good,
  input  logic [VBUS_W-1:0] vbus_state,
  output logic              irq_out
);
  localparam int NGRP     = 3;
  localparam int TOP_BASE = 1 + 4 * NGRP;
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_TSET = ADDR_W'(TOP_BASE + 1);
  localparam logic [ADDR_W-1:0] A_TCLR = ADDR_W'(TOP_BASE + 2);
  localparam logic [ADDR_W-1:0] A_TMSK = ADDR_W'(TOP_BASE + 3);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(TOP_BASE + 4);
  localparam logic [31:0] SUM_BITS = (32'd1 << B_TX) | (32'd1 << B_RX) |
                                     (32'd1 << B_DMA) | (32'd1 << B_GPIO);

  logic [31:0] grp_stat [NGRP];
  logic [31:0] grp_mask [NGRP];
  logic [31:0] grp_evt  [NGRP];
  logic [31:0] grp_pend [NGRP];

  assign grp_evt[0] = core_evt;
  assign grp_evt[1] = dma_evt;
  assign grp_evt[2] = gpio_evt;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(1 + 4 * g + 1);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(1 + 4 * g + 2);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(1 + 4 * g + 3);
    logic [31:0] stat_r, mask_r, set_v, clr_v;
    assign set_v = (bus_we && bus_addr == A_SET) ? bus_wdata : '0;
    assign clr_v = (bus_we && bus_addr == A_CLR) ? bus_wdata : '0;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stat_r <= '0;
        mask_r <= '0;
      end else begin
        stat_r <= (stat_r & ~clr_v) | set_v | grp_evt[g];
        if (bus_we && bus_addr == A_MSK) mask_r <= bus_wdata;
      end
    end
    assign grp_stat[g] = stat_r;
    assign grp_mask[g] = mask_r;
    assign grp_pend[g] = stat_r & ~mask_r;
  end

  logic [31:0] sum_v;
  always_comb begin
    sum_v = '0;
    sum_v[B_TX]   = |grp_pend[0][15:0];
    sum_v[B_RX]   = |grp_pend[0][31:16];
    sum_v[B_DMA]  = |grp_pend[1];
    sum_v[B_GPIO] = |grp_pend[2];
  end

  logic              pol_q;
  logic [31:0]       top_q, top_mask;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [VBUS_W-1:0] vbus_d;
  logic              pwr_d, gate;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [31:0]       top_eff, hw_set, tset_v, tclr_v;
  logic              tmo_wr, tmo_fire, vbus_chg, any_pend;

  assign tmo_wr   = bus_we && bus_addr == A_TMO;
  assign tmo_fire = !tmo_wr && tmo_cnt == TMO_W'(1);
  assign vbus_chg = vbus_state != vbus_d;
  assign hw_set   = ({31'b0, tmo_fire} << B_TMO) | ({31'b0, vbus_chg} << B_VBUS);
  assign tset_v   = (bus_we && bus_addr == A_TSET) ? bus_wdata : '0;
  assign tclr_v   = (bus_we && bus_addr == A_TCLR) ? bus_wdata : '0;
  assign top_eff  = (top_q & ~SUM_BITS) | sum_v;
  assign any_pend = |(top_eff & ~top_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      top_q    <= '0;
      top_mask <= '1;
      tmo_cnt  <= '0;
      vbus_d   <= '0;
    end else begin
      if (bus_we && bus_addr == A_CTRL) pol_q <= bus_wdata[0];
      if (bus_we && bus_addr == A_TMSK) top_mask <= bus_wdata;
      top_q  <= ((top_q & ~tclr_v) | tset_v | hw_set) & ~SUM_BITS;
      vbus_d <= vbus_state;
      if (tmo_wr) tmo_cnt <= bus_wdata[TMO_W-1:0];
      else if (tmo_cnt != '0) tmo_cnt <= tmo_cnt - TMO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_d      <= 1'b0;
      gate       <= 1'b0;
      settle_cnt <= '0;
    end else begin
      pwr_d <= pwr_good;
      if (pwr_good && !pwr_d) begin
        gate       <= 1'b0;
        settle_cnt <= SETTLE_W'(SETTLE_CYCLES);
      end else if (settle_cnt != '0) begin
        settle_cnt <= settle_cnt - SETTLE_W'(1);
        if (settle_cnt == SETTLE_W'(1) && pwr_good) gate <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= (pol_q ? any_pend : !any_pend) && gate;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = {31'b0, pol_q};
    for (int g = 0; g < NGRP; g++) begin
      if (bus_addr >= ADDR_W'(1 + 4 * g) && bus_addr <= ADDR_W'(3 + 4 * g)) bus_rdata = grp_stat[g];
      if (bus_addr == ADDR_W'(4 + 4 * g)) bus_rdata = grp_mask[g];
    end
    if (bus_addr >= ADDR_W'(TOP_BASE) && bus_addr <= A_TCLR) bus_rdata = top_eff;
    if (bus_addr == A_TMSK) bus_rdata = top_mask;
    if (bus_addr == A_TMO)  bus_rdata = 32'(tmo_cnt);
  end

  p_mask_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4)) |=> grp_mask[0] == $past(bus_wdata));
  p_gate_blocks_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !irq_out);
  p_polarity_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && pol_q && any_pend) |=> irq_out);
  p_tmo_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (tmo_cnt == '0) && top_q[B_TMO]);
  p_vbus_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_chg |=> top_q[B_VBUS]);
  p_summary_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_mask[0][15:0] == 16'hFFFF) |-> !top_eff[B_TX]);
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 0, A_CSTAT = 1, A_CSET = 2, A_CCLR = 3, A_CMSK = 4;
  localparam logic [4:0] A_DSTAT = 5, A_DSET = 6, A_DCLR = 7;
  localparam logic [4:0] A_GSET = 10, A_GMSK = 12;
  localparam logic [4:0] A_TSTAT = 13, A_TSET = 14, A_TCLR = 15, A_TMSK = 16, A_TMO = 17;

  typedef struct packed {
    logic        we;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [4:0]  raddr;
    logic [31:0] rexp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, A_CSET, 32'h0001_0003, A_CSTAT, 32'h0001_0003, 8'd1},  // R1 set
    '{1'b0, A_CTRL, 32'h0,         A_TSTAT, 32'h0000_0003, 8'd2},  // R2 TX+RX
    '{1'b1, A_CMSK, 32'h0000_FFFF, A_TSTAT, 32'h0000_0002, 8'd2},  // R2 low half masked
    '{1'b1, A_CCLR, 32'h0001_0000, A_TSTAT, 32'h0000_0000, 8'd2},  // R2 high cleared
    '{1'b0, A_CTRL, 32'h0,         A_CSTAT, 32'h0000_0003, 8'd1},  // R1 raw despite mask
    '{1'b1, A_DSET, 32'h0000_0080, A_TSTAT, 32'h0000_0004, 8'd3},  // R3 DMA
    '{1'b1, A_GSET, 32'h0000_0100, A_TSTAT, 32'h0000_000C, 8'd3},  // R3 GPIO
    '{1'b1, A_GMSK, 32'h0000_0100, A_TSTAT, 32'h0000_0004, 8'd3},  // R3 GPIO masked
    '{1'b1, A_DCLR, 32'h0000_00FF, A_DSTAT, 32'h0000_0000, 8'd1},  // R1 clear
    '{1'b0, A_CTRL, 32'h0,         A_TSTAT, 32'h0000_0000, 8'd3},  // R3 DMA summary gone
    '{1'b1, A_TSET, 32'h8000_0000, A_TSTAT, 32'h8000_0000, 8'd10}, // R10 top set
    '{1'b1, A_TSET, 32'h0000_0001, A_TSTAT, 32'h8000_0000, 8'd2},  // R2 summary write ignored
    '{1'b1, A_TCLR, 32'h8000_0000, A_TSTAT, 32'h0000_0000, 8'd10}, // R10 top clear
    '{1'b0, A_CTRL, 32'h0,         A_CSET,  32'h0000_0003, 8'd1}   // R1 set addr reads status
  };

  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, pwr_good = 1'b0, irq_out;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] core_evt = '0, dma_evt = '0, gpio_evt = '0;
  logic [1:0]  vbus_state = '0;
  int n_chk = 0, n_fail = 0;

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_evt(core_evt),
    .dma_evt(dma_evt), .gpio_evt(gpio_evt), .pwr_good(pwr_good),
    .vbus_state(vbus_state), .irq_out(irq_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    tick(3);
    @(negedge clk) rst_n = 1'b1;
    tick(1);
    rd(A_TMSK, r);  chk("R6 top mask", r, 32'hFFFF_FFFF);
    rd(A_TSTAT, r); chk("R6 top status", r, 32'h0);
    rd(A_CMSK, r);  chk("R6 core mask", r, 32'h0);
    rd(A_TMO, r);   chk("R6 counter", r, 32'h0);
    chk("R6 irq", {31'b0, irq_out}, 32'h0);

    @(negedge clk) pwr_good = 1'b1;
    tick(8);  chk("R7 gate closed while settling", {31'b0, irq_out}, 32'h0);
    tick(22); chk("R7 gate open, R4 low sense idle", {31'b0, irq_out}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, r);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].rexp);
    end

    wr(A_CMSK, 32'h0);
    wr(A_TMSK, 32'hFFFF_FFFE);
    chk("R5 irq unchanged at write edge", {31'b0, irq_out}, 32'h1);
    tick(1);
    chk("R4 low sense with pending TX", {31'b0, irq_out}, 32'h0);
    wr(A_CTRL, 32'h1);
    chk("R5 irq unchanged at ctrl edge", {31'b0, irq_out}, 32'h0);
    tick(1);
    chk("R4 high sense with pending TX", {31'b0, irq_out}, 32'h1);

    wr(A_CCLR, 32'hFFFF_FFFF);
    @(negedge clk) core_evt = 32'h0010_0000;
    @(negedge clk) core_evt = 32'h0;
    rd(A_CSTAT, r); chk("R10 event sets core status", r, 32'h0010_0000);

    wr(A_TMO, 32'd5);
    tick(4);
    rd(A_TMO, r);   chk("R8 count before expiry", r, 32'd1);
    rd(A_TSTAT, r); chk("R8 no flag before expiry", r & 32'h10, 32'h0);
    tick(1);
    rd(A_TMO, r);   chk("R8 count zero at expiry", r, 32'd0);
    rd(A_TSTAT, r); chk("R8 flag at expiry", r & 32'h10, 32'h10);
    wr(A_TCLR, 32'h10);
    wr(A_TMO, 32'd10);
    wr(A_TMO, 32'd0);
    tick(20);
    rd(A_TSTAT, r); chk("R8 stopped counter no flag", r & 32'h10, 32'h0);

    @(negedge clk) vbus_state = 2'b01;
    tick(1);
    rd(A_TSTAT, r); chk("R9 sense change flag", r & 32'h20, 32'h20);

    wr(A_CTRL, 32'h0);
    wr(A_TMSK, 32'hFFFF_FFFF);
    tick(1);
    chk("R4 idle low sense", {31'b0, irq_out}, 32'h1);
    @(negedge clk) pwr_good = 1'b0;
    tick(2);
    @(negedge clk) pwr_good = 1'b1;
    tick(3);
    chk("R7 rising edge closes gate", {31'b0, irq_out}, 32'h0);
    tick(30);
    chk("R7 gate reopens", {31'b0, irq_out}, 32'h1);
    @(negedge clk) pwr_good = 1'b0;
    tick(1);
    @(negedge clk) pwr_good = 1'b1;
    tick(3);
    @(negedge clk) pwr_good = 1'b0;
    tick(30);
    chk("R7 power lost during settle keeps gate closed", {31'b0, irq_out}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule